// File: doc/BRIEF.md
# Receive Packet Admission Gate

This block sits between a receive packet stream and the DMA engine that writes packets into descriptor-backed buffers. At the first beat of each packet it decides whether the packet goes to memory or is thrown away. A packet is admitted only if at least one descriptor is available on its start beat. If none is available, every beat of that packet is discarded and one drop event is signalled. If the descriptors run out after a packet has been admitted, the packet is not dropped. Its remaining beats are discarded and its receive status word is marked with a descriptor-error flag.

A read-data error halts the channel. While halted or disabled, the gate takes no data, signals no drop events and writes no status words. The halt is sticky and clears only when the channel enable is taken low and then high again. Every output is registered, so each output shows the result for the inputs of the previous clock cycle.

Top module: `rx_admit_gate`

## Requirements
- R1: A valid beat with `beat_sop`=1 and `dscr_avail`=0 is discarded (`beat_drop`=1) and gives a one-cycle `drop_evt`. The other beats of that packet, up to and including the `beat_eop` beat, are discarded. They produce no event and no status word.
- R2: After a dropped packet, beats keep being discarded until a start beat arrives with `dscr_avail`>0. Each further start beat that finds `dscr_avail`=0 gives its own `drop_evt`.
- R3: A start beat with `dscr_avail`>0 is accepted (`beat_keep`=1), and so are the later beats of its packet. The end beat of the packet raises `stat_vld`=1 with `stat_dscr_err`=0. A packet of one beat, with start and end on the same beat, behaves the same way.
- R4: Inside an admitted packet, a beat with `buf_exhausted`=1 is discarded, and so is every later beat of that packet. The end beat raises `stat_vld`=1 with `stat_dscr_err`=1. No `drop_evt` is raised.
- R5: `dscr_avail` is looked at only on start beats. Its value on any other beat has no effect.
- R6: `rd_err`=1 while `chan_en`=1 sets `chan_stopped` one cycle later, and the beat in that cycle is not accepted. `rd_err` has no effect while `chan_en`=0.
- R7: `chan_stopped` stays set until a cycle in which `chan_en` is high after being low in the cycle before. In that cycle the halt clears, but the beat of that cycle is not yet accepted.
- R8: While the channel is halted or disabled, every valid beat is discarded. No `drop_evt` and no status word is produced. Any packet that was in progress is abandoned.
- R9: A valid beat without `beat_sop` that arrives outside any packet is discarded without a `drop_evt`.
- R10: When `rd_err` and a start beat with `dscr_avail`=0 fall in the same cycle, the halt wins: the beat is discarded, `chan_stopped` sets and no `drop_evt` is raised.
- R11: All outputs are registered with one cycle of latency, and all of them are 0 during and right after reset.
- R12: For every valid beat exactly one of `beat_keep` and `beat_drop` is 1. With no valid beat, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; a low-to-high change clears a halt |
| rd_err | input | 1 | Read data carried an error mark |
| beat_vld | input | 1 | A packet data beat is present |
| beat_sop | input | 1 | The beat is the first of a packet |
| beat_eop | input | 1 | The beat is the last of a packet |
| dscr_avail | input | DCNT_W | Count of available descriptors |
| buf_exhausted | input | 1 | No descriptor is left for further data of the current packet |
| beat_keep | output | 1 | The previous beat is accepted for writing |
| beat_drop | output | 1 | The previous beat is discarded |
| drop_evt | output | 1 | Pulse: a packet was dropped at its start |
| stat_vld | output | 1 | A receive status word is written for an admitted packet |
| stat_dscr_err | output | 1 | The descriptor-error bit of that status word |
| chan_stopped | output | 1 | The channel is halted by a read error |

## Verification
Two pairs of functions can meet in the same cycle. The first pair is the halt path and the start-of-packet drop decision. The bench drives `rd_err` together with a start beat that finds no descriptors, and expects a discarded beat, a set halt and no drop event. The second pair is the end-of-packet status write and descriptor exhaustion. The bench raises `buf_exhausted` on the end beat itself, and expects a discarded beat together with a status word whose error bit is set. Every cycle's expected outputs are queued by the driver and compared one cycle later, so a collision that leaks into either function shows up in the cycle where it happens.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_TAKE  = 2'd1,
    GS_SKIP  = 2'd2,
    GS_TRUNC = 2'd3
  } gate_st_e;

  typedef struct packed {
    logic keep;
    logic drop;
    logic evt;
    logic svld;
    logic serr;
  } gate_out_s;
endpackage

// File: rtl/rxg_fault.sv
module rxg_fault (
  input  logic clk,
  input  logic rst,
  input  logic chan_en,
  input  logic rd_err,
  output logic stopped,
  output logic active
);
  logic stop_q;
  logic en_q;
  logic en_rise;

  assign en_rise = chan_en & ~en_q;
  assign active  = chan_en & ~stop_q & ~rd_err;
  assign stopped = stop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      en_q <= chan_en;
      if (chan_en && rd_err)
        stop_q <= 1'b1;
      else if (en_rise)
        stop_q <= 1'b0;
    end
  end

  // R6
  err_halts_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_en && rd_err) |=> stop_q);

  // R7
  halt_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stop_q) |-> ($past(chan_en) && !$past(en_q)));
endmodule

// File: rtl/rxg_admit.sv
module rxg_admit
  import rxg_pkg::*;
#(
  parameter int DCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              beat_vld,
  input  logic              beat_sop,
  input  logic              beat_eop,
  input  logic [DCNT_W-1:0] dscr_avail,
  input  logic              buf_exhausted,
  output gate_out_s         out_q
);
  gate_st_e  st_q, st_n;
  gate_out_s o_n;
  logic      none_left;

  assign none_left = (dscr_avail == '0);

  always_comb begin
    st_n = st_q;
    o_n  = '0;
    if (!active) begin
      st_n = GS_IDLE;
    end else if (beat_vld) begin
      if (beat_sop) begin
        if (none_left) begin
          o_n.evt = 1'b1;
          st_n    = beat_eop ? GS_IDLE : GS_SKIP;
        end else begin
          o_n.keep = 1'b1;
          o_n.svld = beat_eop;
          st_n     = beat_eop ? GS_IDLE : GS_TAKE;
        end
      end else begin
        unique case (st_q)
          GS_TAKE: begin
            if (buf_exhausted) begin
              o_n.svld = beat_eop;
              o_n.serr = beat_eop;
              st_n     = beat_eop ? GS_IDLE : GS_TRUNC;
            end else begin
              o_n.keep = 1'b1;
              o_n.svld = beat_eop;
              st_n     = beat_eop ? GS_IDLE : GS_TAKE;
            end
          end
          GS_TRUNC: begin
            o_n.svld = beat_eop;
            o_n.serr = beat_eop;
            st_n     = beat_eop ? GS_IDLE : GS_TRUNC;
          end
          GS_SKIP: st_n = beat_eop ? GS_IDLE : GS_SKIP;
          default: st_n = GS_IDLE;
        endcase
      end
    end
    o_n.drop = beat_vld & ~o_n.keep;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= GS_IDLE;
      out_q <= '0;
    end else begin
      st_q  <= st_n;
      out_q <= o_n;
    end
  end

  // R12
  keep_drop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_q.keep && out_q.drop));

  // R1
  evt_from_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_q.evt) |-> $past(beat_vld && beat_sop && active));

  // R8
  halted_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!out_q.keep && !out_q.evt && !out_q.svld));

  // R3
  clean_status_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (out_q.svld && !out_q.serr) |-> out_q.keep);
endmodule

// File: rtl/rx_admit_gate.sv
module rx_admit_gate
  import rxg_pkg::*;
#(
  parameter int DCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_en,
  input  logic              rd_err,
  input  logic              beat_vld,
  input  logic              beat_sop,
  input  logic              beat_eop,
  input  logic [DCNT_W-1:0] dscr_avail,
  input  logic              buf_exhausted,
  output logic              beat_keep,
  output logic              beat_drop,
  output logic              drop_evt,
  output logic              stat_vld,
  output logic              stat_dscr_err,
  output logic              chan_stopped
);
  logic      active;
  gate_out_s gate_q;

  rxg_fault u_fault (
    .clk     (clk),
    .rst     (rst),
    .chan_en (chan_en),
    .rd_err  (rd_err),
    .stopped (chan_stopped),
    .active  (active)
  );

  rxg_admit #(.DCNT_W(DCNT_W)) u_admit (
    .clk           (clk),
    .rst           (rst),
    .active        (active),
    .beat_vld      (beat_vld),
    .beat_sop      (beat_sop),
    .beat_eop      (beat_eop),
    .dscr_avail    (dscr_avail),
    .buf_exhausted (buf_exhausted),
    .out_q         (gate_q)
  );

  assign beat_keep     = gate_q.keep;
  assign beat_drop     = gate_q.drop;
  assign drop_evt      = gate_q.evt;
  assign stat_vld      = gate_q.svld;
  assign stat_dscr_err = gate_q.serr;

  // R10
  halt_beats_event_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_en && rd_err && beat_vld && beat_sop) |=> (!drop_evt && chan_stopped));
endmodule

// File: tb/sim_rx_admit_gate.sv
module sim_rx_admit_gate;
  localparam int CLK_P  = 10;
  localparam int DCNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chan_en = 1'b0, rd_err = 1'b0;
  logic beat_vld = 1'b0, beat_sop = 1'b0, beat_eop = 1'b0, buf_exhausted = 1'b0;
  logic [DCNT_W-1:0] dscr_avail = '0;
  logic beat_keep, beat_drop, drop_evt, stat_vld, stat_dscr_err, chan_stopped;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [5:0] val;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_P/2) clk = ~clk;

  rx_admit_gate #(.DCNT_W(DCNT_W)) u0 (
    .clk(clk), .rst(rst), .chan_en(chan_en), .rd_err(rd_err),
    .beat_vld(beat_vld), .beat_sop(beat_sop), .beat_eop(beat_eop),
    .dscr_avail(dscr_avail), .buf_exhausted(buf_exhausted),
    .beat_keep(beat_keep), .beat_drop(beat_drop), .drop_evt(drop_evt),
    .stat_vld(stat_vld), .stat_dscr_err(stat_dscr_err), .chan_stopped(chan_stopped)
  );

  // One cycle of stimulus. Expected fields are {keep,drop,evt,svld,serr,stopped}.
  task automatic cyc(input bit en, input bit err, input bit v, input bit s, input bit e,
                     input int av, input bit ex, input logic [5:0] expv, input string tag);
    exp_t it;
    @(negedge clk);
    chan_en = en; rd_err = err; beat_vld = v; beat_sop = s; beat_eop = e;
    dscr_avail = DCNT_W'(av); buf_exhausted = ex;
    it.val = expv; it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: each posedge, compare the outputs against the item queued before it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        logic [5:0] act;
        it  = q.pop_front();
        act = {beat_keep, beat_drop, drop_evt, stat_vld, stat_dscr_err, chan_stopped};
        checks++;
        if (act !== it.val) begin
          errors++;
          $display("FAIL %s: outputs k,d,e,sv,se,st actual=%b expected=%b", it.tag, act, it.val);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({beat_keep, beat_drop, drop_evt, stat_vld, stat_dscr_err, chan_stopped} !== 6'b0) begin
      errors++;
      $display("FAIL R11: reset outputs actual=%b expected=000000",
               {beat_keep, beat_drop, drop_evt, stat_vld, stat_dscr_err, chan_stopped});
    end
    @(negedge clk); rst = 1'b0;

    cyc(0,0,0,0,0,0,0, 6'b000000, "R11");
    // R9 stray beat outside a packet
    cyc(1,0,1,0,0,5,0, 6'b010000, "R9");
    // R3 and R5: admitted packet; descriptor count falls to zero mid-packet
    cyc(1,0,1,1,0,3,0, 6'b100000, "R3");
    cyc(1,0,1,0,0,0,0, 6'b100000, "R5");
    cyc(1,0,1,0,1,0,0, 6'b100100, "R3");
    // R1: no descriptors at start, the whole packet goes
    cyc(1,0,1,1,0,0,0, 6'b011000, "R1");
    cyc(1,0,1,0,0,5,0, 6'b010000, "R5");
    cyc(1,0,1,0,1,5,0, 6'b010000, "R1");
    cyc(1,0,1,0,0,5,0, 6'b010000, "R2");
    // R2: repeated drops, each with its own event, then recovery
    cyc(1,0,1,1,1,0,0, 6'b011000, "R2");
    cyc(1,0,1,1,0,0,0, 6'b011000, "R2");
    cyc(1,0,1,0,1,0,0, 6'b010000, "R2");
    cyc(1,0,1,1,0,2,0, 6'b100000, "R2");
    cyc(1,0,1,0,1,2,0, 6'b100100, "R2");
    // R4: descriptors run out mid-packet
    cyc(1,0,1,1,0,2,0, 6'b100000, "R4");
    cyc(1,0,1,0,0,2,0, 6'b100000, "R4");
    cyc(1,0,1,0,0,2,1, 6'b010000, "R4");
    cyc(1,0,1,0,0,2,0, 6'b010000, "R4");
    cyc(1,0,1,0,1,2,0, 6'b010110, "R4");
    // R3 single-beat packet
    cyc(1,0,1,1,1,1,0, 6'b100100, "R3");
    // R4 exhaustion on the end beat itself
    cyc(1,0,1,1,0,1,0, 6'b100000, "R4");
    cyc(1,0,1,0,1,1,1, 6'b010110, "R4");
    // R10: halt and start-drop in the same cycle
    cyc(1,1,1,1,0,0,0, 6'b010001, "R10");
    // R8: halted gate takes nothing and signals nothing
    cyc(1,0,1,1,0,4,0, 6'b010001, "R8");
    cyc(1,0,1,0,1,4,0, 6'b010001, "R8");
    cyc(1,0,1,1,1,0,0, 6'b010001, "R8");
    cyc(1,0,0,0,0,0,0, 6'b000001, "R7");
    // R7: disable, then re-enable clears the halt
    cyc(0,0,0,0,0,0,0, 6'b000001, "R7");
    cyc(0,0,1,1,0,0,0, 6'b010001, "R8");
    cyc(1,0,1,1,0,3,0, 6'b010000, "R7");
    cyc(1,0,1,0,1,3,0, 6'b010000, "R9");
    cyc(1,0,1,1,0,3,0, 6'b100000, "R7");
    cyc(1,0,1,0,1,3,0, 6'b100100, "R7");
    // R6: read error inside an admitted packet
    cyc(1,0,1,1,0,3,0, 6'b100000, "R6");
    cyc(1,1,1,0,0,3,0, 6'b010001, "R6");
    cyc(1,0,1,0,1,3,0, 6'b010001, "R6");
    cyc(0,0,0,0,0,0,0, 6'b000001, "R7");
    cyc(1,0,0,0,0,0,0, 6'b000000, "R7");
    // R8: disable in mid-packet abandons it
    cyc(1,0,1,1,0,1,0, 6'b100000, "R8");
    cyc(0,0,1,0,0,1,0, 6'b010000, "R8");
    cyc(1,0,0,0,0,1,0, 6'b000000, "R8");
    cyc(1,0,1,0,1,1,0, 6'b010000, "R8");
    // R6: read error while disabled is ignored
    cyc(0,1,0,0,0,0,0, 6'b000000, "R6");
    cyc(1,0,1,1,1,2,0, 6'b100100, "R6");
    // R12 idle cycle: neither keep nor drop
    cyc(1,0,0,0,0,2,0, 6'b000000, "R12");
    cyc(1,0,0,0,0,0,0, 6'b000000, "R12");

    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule